// File: doc/BRIEF.md
# Display Link Power Sequencer

This controller decides when a display module's logic supply and its video data/control link may be switched on and off. A host raises a power request; the controller turns on the logic supply, waits for a power-good indication, and only then, after a programmable delay, lets the link carry data. When the request goes away, the link is shut first and the supply follows after a second programmable delay. Once the supply is off it stays off for a long minimum rest time before any new power-up.

All windows are counted in ticks of a millisecond strobe supplied from outside, so the same logic runs at any clock rate and a bench can use a fast strobe. Both programmable delays are capped at the widest window the link allows. A supply that never reports good, or that drops while in use, raises a fault flag that blocks any restart until the request is withdrawn.

Top module: `pwr_link_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, supply_en, link_en, ready and fault are all 0.
- R2: With fault clear and the sequencer idle, a high pwr_req makes supply_en go high on the clock edge that first samples it, with link_en still 0.
- R3: After pwr_good is first sampled high during ramp-up, link_en rises after exactly min(cfg_on_ms, DATA_MAX_MS) ms ticks have been counted (ticks in the cycle that sees pwr_good and in the cycle that leaves the wait are not counted); ready is high exactly when link_en is high, and link_en never rises without pwr_good sampled high the cycle before.
- R4: Any delay setting above DATA_MAX_MS (default 50) behaves exactly as DATA_MAX_MS, for both the power-on and the power-off delay.
- R5: When pwr_req falls while the link is live, link_en drops on the next edge while supply_en stays high, and supply_en drops after exactly min(cfg_off_ms, DATA_MAX_MS) further ticks (same counting rule as R3).
- R6: Once supply_en falls, it stays low for at least COOL_MS ticks (default 500); a request that is high during the rest period is served on expiry, so supply_en rises after exactly COOL_MS ticks counted while it was low.
- R7: If pwr_good has not been seen after RAMP_LIMIT_MS ticks (default 10) of ramp-up, fault rises and supply_en drops on the same edge.
- R8: While fault is high the sequencer does not restart even with pwr_req high; fault clears on the edge after pwr_req is sampled low in the idle state, after which a request powers up normally.
- R9: If pwr_good drops while the link is live, link_en, ready and supply_en all drop and fault rises on the next edge.
- R10: link_en is never high while supply_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe marking each millisecond |
| pwr_req | input | 1 | Host request: high to power up, low to power down |
| pwr_good | input | 1 | Logic supply has reached its valid level |
| cfg_on_ms | input | CFG_W | Delay in ms from supply good to link on |
| cfg_off_ms | input | CFG_W | Delay in ms from link off to supply off |
| supply_en | output | 1 | Enables the logic supply |
| link_en | output | 1 | Enables the video data/control link |
| ready | output | 1 | Link is live |
| fault | output | 1 | Supply failed to come up or was lost |

## Verification
The full up/down cycle is repeated with power-on and power-off delays that include zero, one, mid values, exactly the cap and above the cap, so a wrong comparison, an off-by-one count or a missing clamp each shows up as a tick count that differs from the bench's own min() arithmetic. The rest period is measured with the request held high throughout, which separates a correct 500-tick hold from both early restart and a lost request. A supply that never reports good and one that drops while live tell apart the timeout path, the live-loss path and the rule that a fault blocks restart until the request is withdrawn.

// File: rtl/pls_pkg.sv
package pls_pkg;

  typedef enum logic [2:0] {
    PS_IDLE      = 3'd0,
    PS_RAMP      = 3'd1,
    PS_WAIT_LINK = 3'd2,
    PS_LIVE      = 3'd3,
    PS_DRAIN     = 3'd4,
    PS_REST      = 3'd5
  } pseq_state_t;

  // Limit a requested delay to a ceiling.
  function automatic int unsigned cap_ms(input int unsigned want,
                                         input int unsigned ceiling);
    return (want > ceiling) ? ceiling : want;
  endfunction

  // The supply rail is driven in every state between ramp and drain.
  function automatic logic rail_on(input pseq_state_t s);
    return (s == PS_RAMP) || (s == PS_WAIT_LINK) || (s == PS_LIVE) || (s == PS_DRAIN);
  endfunction

endpackage

// File: rtl/pls_tick_timer.sv
module pls_tick_timer #(
  parameter int W   = 9,
  parameter int MAX = 500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = W'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (tick && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/pls_seq_fsm.sv
module pls_seq_fsm
  import pls_pkg::*;
#(
  parameter int CNT_W         = 9,
  parameter int RAMP_LIMIT_MS = 10,
  parameter int COOL_MS       = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_req,
  input  logic             pwr_good,
  input  logic [CNT_W-1:0] elapsed,
  input  logic [CNT_W-1:0] on_lim,
  input  logic [CNT_W-1:0] off_lim,
  output pseq_state_t      state,
  output logic             leave,
  output logic             fault,
  output logic             fault_evt
);

  localparam logic [CNT_W-1:0] RAMP_TO = CNT_W'(RAMP_LIMIT_MS);
  localparam logic [CNT_W-1:0] REST_TO = CNT_W'(COOL_MS);

  pseq_state_t nxt;
  logic        fault_clr;

  always_comb begin
    nxt       = state;
    fault_evt = 1'b0;
    fault_clr = 1'b0;
    unique case (state)
      PS_IDLE: begin
        if (!pwr_req) fault_clr = 1'b1;
        else if (!fault) nxt = PS_RAMP;
      end
      PS_RAMP: begin
        if (!pwr_req) begin
          nxt = PS_REST;
        end else if (pwr_good) begin
          nxt = PS_WAIT_LINK;
        end else if (elapsed >= RAMP_TO) begin
          nxt       = PS_REST;
          fault_evt = 1'b1;
        end
      end
      PS_WAIT_LINK: begin
        if (!pwr_good) begin
          nxt       = PS_REST;
          fault_evt = 1'b1;
        end else if (!pwr_req) begin
          nxt = PS_REST;
        end else if (elapsed >= on_lim) begin
          nxt = PS_LIVE;
        end
      end
      PS_LIVE: begin
        if (!pwr_good) begin
          nxt       = PS_REST;
          fault_evt = 1'b1;
        end else if (!pwr_req) begin
          nxt = PS_DRAIN;
        end
      end
      PS_DRAIN: begin
        if (!pwr_good || (elapsed >= off_lim)) nxt = PS_REST;
      end
      PS_REST: begin
        if (elapsed >= REST_TO) nxt = PS_IDLE;
      end
      default: nxt = PS_IDLE;
    endcase
  end

  assign leave = (nxt != state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PS_IDLE;
      fault <= 1'b0;
    end else begin
      state <= nxt;
      if (fault_evt)      fault <= 1'b1;
      else if (fault_clr) fault <= 1'b0;
    end
  end

endmodule

// File: rtl/pls_out_decode.sv
module pls_out_decode
  import pls_pkg::*;
(
  input  pseq_state_t state,
  output logic        supply_en,
  output logic        link_en,
  output logic        ready
);

  always_comb begin
    supply_en = rail_on(state);
    link_en   = (state == PS_LIVE);
    ready     = (state == PS_LIVE);
  end

endmodule

// File: rtl/pwr_link_seq.sv
module pwr_link_seq
  import pls_pkg::*;
#(
  parameter int RAMP_LIMIT_MS = 10,
  parameter int DATA_MAX_MS   = 50,
  parameter int COOL_MS       = 500,
  parameter int CFG_W         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             pwr_req,
  input  logic             pwr_good,
  input  logic [CFG_W-1:0] cfg_on_ms,
  input  logic [CFG_W-1:0] cfg_off_ms,
  output logic             supply_en,
  output logic             link_en,
  output logic             ready,
  output logic             fault
);

  localparam int CNT_W = $clog2(COOL_MS + 1);

  logic [CNT_W-1:0] on_lim;
  logic [CNT_W-1:0] off_lim;
  logic [CNT_W-1:0] elapsed;
  logic             leave;
  logic             fault_evt;
  pseq_state_t      state;

  assign on_lim  = CNT_W'(cap_ms(32'(cfg_on_ms),  DATA_MAX_MS));
  assign off_lim = CNT_W'(cap_ms(32'(cfg_off_ms), DATA_MAX_MS));

  pls_tick_timer #(.W(CNT_W), .MAX(COOL_MS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (leave),
    .tick  (ms_tick),
    .count (elapsed)
  );

  pls_seq_fsm #(
    .CNT_W         (CNT_W),
    .RAMP_LIMIT_MS (RAMP_LIMIT_MS),
    .COOL_MS       (COOL_MS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_req   (pwr_req),
    .pwr_good  (pwr_good),
    .elapsed   (elapsed),
    .on_lim    (on_lim),
    .off_lim   (off_lim),
    .state     (state),
    .leave     (leave),
    .fault     (fault),
    .fault_evt (fault_evt)
  );

  pls_out_decode u_dec (
    .state     (state),
    .supply_en (supply_en),
    .link_en   (link_en),
    .ready     (ready)
  );

endmodule

// File: rtl/pls_seq_checker.sv
module pls_seq_checker #(
  parameter int COOL_MS     = 500,
  parameter int DATA_MAX_MS = 50
) (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic pwr_good,
  input logic supply_en,
  input logic link_en,
  input logic ready,
  input logic fault,
  input logic fault_evt
);

  localparam int DW = $clog2(DATA_MAX_MS + 2);
  localparam int RW = $clog2(COOL_MS + 1);

  logic          draining;
  logic [DW-1:0] dcnt;
  logic [RW-1:0] rcnt;
  logic          primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining <= 1'b0;
      dcnt     <= '0;
    end else if (link_en) begin
      draining <= 1'b1;
      dcnt     <= '0;
    end else if (!supply_en) begin
      draining <= 1'b0;
    end else if (draining && ms_tick && (dcnt != {DW{1'b1}})) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt   <= '0;
      primed <= 1'b0;
    end else begin
      primed <= primed | supply_en;
      if (supply_en) rcnt <= '0;
      else if (ms_tick && (rcnt != RW'(COOL_MS))) rcnt <= rcnt + 1'b1;
    end
  end

  assert_link_needs_supply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_en |-> supply_en);

  assert_ready_tracks_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> link_en);

  assert_link_after_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_en) |-> $past(pwr_good));

  assert_link_drops_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(supply_en) && !fault) |-> !$past(link_en));

  assert_fault_cuts_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !supply_en);

  assert_fault_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> fault);

  assert_drain_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && supply_en) |-> (dcnt <= DW'(DATA_MAX_MS)));

  assert_rest_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(supply_en) && primed) |-> (rcnt >= RW'(COOL_MS)));

endmodule

bind pwr_link_seq pls_seq_checker #(
  .COOL_MS     (COOL_MS),
  .DATA_MAX_MS (DATA_MAX_MS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ms_tick   (ms_tick),
  .pwr_good  (pwr_good),
  .supply_en (supply_en),
  .link_en   (link_en),
  .ready     (ready),
  .fault     (fault),
  .fault_evt (fault_evt)
);

// File: tb/pwr_link_seq_test.sv
module pwr_link_seq_test;

  localparam int CLK_P   = 10;
  localparam int TDIV    = 4;
  localparam int CAP     = 50;
  localparam int REST    = 500;
  localparam int RAMP_TO = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       pwr_req = 1'b0;
  logic       pwr_good = 1'b0;
  logic [5:0] cfg_on_ms = '0;
  logic [5:0] cfg_off_ms = '0;
  logic       supply_en, link_en, ready, fault;

  int checks = 0;
  int fails  = 0;
  int r10_bad = 0;

  pwr_link_seq uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_req(pwr_req),
    .pwr_good(pwr_good), .cfg_on_ms(cfg_on_ms), .cfg_off_ms(cfg_off_ms),
    .supply_en(supply_en), .link_en(link_en), .ready(ready), .fault(fault)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #1;
      ms_tick = (div == TDIV - 1);
      div = (div == TDIV - 1) ? 0 : div + 1;
    end
  end

  always @(negedge clk) if (rst_n && link_en && !supply_en) r10_bad++;

  function automatic int lim(input int v);
    return (v > CAP) ? CAP : v;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic after_edge(); @(posedge clk); #1; endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // One full up/down cycle; entry: either idle (first) or just entered ramp.
  task automatic run_cycle(input int on_d, input int off_d, input bit first);
    int n; int g; logic pend;
    cfg_on_ms = 6'(on_d);
    cfg_off_ms = 6'(off_d);
    if (first) begin
      after_edge(); pwr_req = 1'b1;
      @(negedge clk); @(negedge clk);
      check(supply_en && !link_en, "R2 supply on after request", supply_en, 1);
    end
    repeat (3) after_edge();
    pwr_good = 1'b1;
    @(negedge clk);
    n = 0; pend = 1'b0; g = 0;
    forever begin
      @(negedge clk);
      if (link_en || g > 4000) break;
      n += int'(pend); pend = ms_tick; g++;
    end
    check(n == lim(on_d), (on_d > CAP) ? "R4 on delay capped" : "R3 on delay", n, lim(on_d));
    check(ready == 1'b1, "R3 ready with link", ready, 1);
    repeat (5) after_edge();
    pwr_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!link_en && supply_en, "R5 link drops first", link_en, 0);
    n = 0; pend = ms_tick; g = 0;
    forever begin
      @(negedge clk);
      if (!supply_en || g > 4000) break;
      n += int'(pend); pend = ms_tick; g++;
    end
    check(n == lim(off_d), (off_d > CAP) ? "R4 off delay capped" : "R5 off delay", n, lim(off_d));
    n = int'(ms_tick); g = 0;
    after_edge(); pwr_good = 1'b0;
    after_edge(); pwr_req = 1'b1;
    forever begin
      @(negedge clk);
      if (supply_en || g > 8000) break;
      n += int'(ms_tick); g++;
    end
    check(n == REST, "R6 rest time with held request", n, REST);
  endtask

  initial begin
    int on_v[5]  = '{0, 1, 7, 50, 63};
    int off_v[5] = '{3, 0, 50, 63, 12};
    int n; int g; logic pend;

    repeat (4) @(negedge clk);
    check(!supply_en && !link_en && !ready && !fault, "R1 outputs in reset", supply_en, 0);
    after_edge(); rst_n = 1'b1;
    @(negedge clk);
    check(!supply_en && !link_en && !ready && !fault, "R1 outputs after reset", link_en, 0);

    for (int i = 0; i < 5; i++) run_cycle(on_v[i], off_v[i], i == 0);

    // Now in ramp with pwr_good low: timeout.
    n = 0; pend = 1'b0; g = 0;
    forever begin
      if (fault || g > 4000) break;
      n += int'(pend); pend = ms_tick; g++;
      @(negedge clk);
    end
    check(n == RAMP_TO, "R7 ramp timeout ticks", n, RAMP_TO);
    check(fault && !supply_en, "R7 fault cuts supply", supply_en, 0);

    repeat ((REST + 30) * TDIV) @(negedge clk);
    check(!supply_en && fault, "R8 no restart while fault", supply_en, 0);
    after_edge(); pwr_req = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!fault, "R8 fault cleared by request low", fault, 0);
    after_edge(); pwr_req = 1'b1;
    @(negedge clk); @(negedge clk);
    check(supply_en, "R8 restart after clear", supply_en, 1);

    cfg_on_ms = 6'd2;
    after_edge(); pwr_good = 1'b1;
    g = 0;
    while (!link_en && g < 4000) begin @(negedge clk); g++; end
    check(link_en && ready, "R3 link live before loss", link_en, 1);
    after_edge(); pwr_good = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!link_en && !ready && !supply_en && fault, "R9 loss while live", fault, 1);

    check(r10_bad == 0, "R10 link without supply", r10_bad, 0);
    finish_run();
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule